// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block keeps track of interrupt requests for a two-channel serial controller. For each channel it records whether a receive interrupt and a transmit interrupt are pending and whether each is currently being serviced. From that state it builds one interrupt request line, a shared byte that shows which sources are pending, and a shared interrupt vector byte. The vector byte's encoding depends on a status-high/status-low select.

Channel A is index 0 and channel B is index 1. Per-channel events and commands go into a single-action-per-cycle arbiter. Receive service has precedence over transmit service. When one source is cleared, the other source is posted again if it is still pending. All state changes on the clock edge that samples the event, and the request output is a register loaded on that same edge.

Top module: `sio_irq_vector`

## Requirements
- R1: While `rstN` is low, all pending and in-service flags clear. `pendStatus`, `intVector` and `irq` all read 0x00 / 0.
- R2: A receive event sets that channel's rx-pending and rx-in-service flags. It sets the rx status bit (bit 5 for A, bit 2 for B) and loads the rx vector. The rx vector is A 0x30 / B 0x20 when `statusHi` is 1, and A 0x0C / B 0x04 when `statusHi` is 0.
- R3: A transmit event sets tx-pending. If rx is not in service on that channel, it also sets tx-in-service and loads the tx vector: A 0x10 (`statusHi`=1) or 0x08 (`statusHi`=0), B 0x00 in both cases. In that same case it sets the tx status bit (bit 4 for A, bit 1 for B), but only if that channel's `txIntEn` is 1.
- R4: A transmit event on a channel whose rx is in service leaves `intVector` and `pendStatus` unchanged. It only records tx-pending.
- R5: Command code 3'b111 clears rx-in-service and re-posts a pending tx as in R3, if rx was in service. Otherwise it clears tx-in-service and leaves `intVector` unchanged.
- R6: Command code 3'b101 clears tx-pending, tx-in-service and the tx status bit, and loads the no-interrupt vector (0x60 when `statusHi` is 1, 0x06 when it is 0). It then re-posts a pending rx as in R2.
- R7: A data read clears rx-pending, rx-in-service and the rx status bit, and loads the no-interrupt vector. It then re-posts a pending tx as in R3.
- R8: `irq` is 1 one edge after any channel meets one of these conditions: `txIntEn` with tx-pending; rx mode (`rxIntMode[2c+1:2c]`) equal to 2'b01 or 2'b10 with rx-pending; or `brkIntEn` with `brkStatus`.
- R9: A channel reset clears that channel's four flags and its two status bits. It leaves the other channel and `intVector` unchanged.
- R10: Only one action is applied per cycle. The order is: channel A before channel B, and within a channel reset, data read, command 101, command 111, receive, transmit. All other command codes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| statusHi | input | 1 | Vector encoding select (1 = high form) |
| txIntEn | input | 2 | Per-channel tx interrupt enable |
| rxIntMode | input | 4 | Per-channel rx interrupt mode, 2 bits each |
| brkIntEn | input | 2 | Per-channel break interrupt enable |
| brkStatus | input | 2 | Per-channel break condition level |
| rxEvent | input | 2 | Per-channel byte received strobe |
| txEvent | input | 2 | Per-channel data written strobe |
| dataRead | input | 2 | Per-channel receive data read strobe |
| cmdWrite | input | 2 | Per-channel command strobe |
| cmdCode | input | 6 | Command codes, 3 bits per channel |
| chanReset | input | 2 | Per-channel reset strobe |
| irq | output | 1 | Registered interrupt request |
| pendStatus | output | 8 | Shared pending-source byte |
| intVector | output | 8 | Shared modified vector byte |

## Verification
Every result is due on the first rising edge that samples the event: the flags, `pendStatus`, `intVector` and `irq` all update on that edge, with no extra stage. The bench drives each stimulus at a falling edge and advances its behavioural model once per rising edge. It compares all three outputs at the following falling edge, so each check falls one full edge after its cause and never on the edge itself. Directed sequences cover re-posting, status-select changes, break requests and simultaneous actions. A random phase then stacks several actions in the same cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NUM_CHAN = 2;
  localparam int CMD_W = 3;
  localparam int MODE_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [CMD_W-1:0] CMD_CLR_TX = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RST_SVC = 3'b111;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RESET, ACT_READ, ACT_CLRTX, ACT_RSTSVC, ACT_RX, ACT_TX
  } actKind_e;

  typedef struct packed {
    actKind_e kind;
    logic chan;
  } actStrobe_t;

  function automatic logic [BYTE_W-1:0] rxVec(input logic ch, input logic hi);
    if (hi) return ch ? 8'h20 : 8'h30;
    return ch ? 8'h04 : 8'h0C;
  endfunction

  function automatic logic [BYTE_W-1:0] txVec(input logic ch, input logic hi);
    if (ch) return 8'h00;
    return hi ? 8'h10 : 8'h08;
  endfunction

  function automatic logic [BYTE_W-1:0] idleVec(input logic hi);
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [BYTE_W-1:0] rxMask(input logic ch);
    return ch ? 8'h04 : 8'h20;
  endfunction

  function automatic logic [BYTE_W-1:0] txMask(input logic ch);
    return ch ? 8'h02 : 8'h10;
  endfunction
endpackage

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
  import sio_irq_pkg::*;
(
  input  logic [NUM_CHAN-1:0]       chanReset,
  input  logic [NUM_CHAN-1:0]       dataRead,
  input  logic [NUM_CHAN-1:0]       cmdWrite,
  input  logic [NUM_CHAN*CMD_W-1:0] cmdCode,
  input  logic [NUM_CHAN-1:0]       rxEvent,
  input  logic [NUM_CHAN-1:0]       txEvent,
  output actStrobe_t                act
);
  // Later assignments win: lowest channel and highest-ranked kind go last.
  always_comb begin
    act = '{kind: ACT_NONE, chan: 1'b0};
    for (int c = NUM_CHAN - 1; c >= 0; c--) begin
      if (txEvent[c]) act = '{kind: ACT_TX, chan: 1'(c)};
      if (rxEvent[c]) act = '{kind: ACT_RX, chan: 1'(c)};
      if (cmdWrite[c] && cmdCode[c*CMD_W +: CMD_W] == CMD_RST_SVC)
        act = '{kind: ACT_RSTSVC, chan: 1'(c)};
      if (cmdWrite[c] && cmdCode[c*CMD_W +: CMD_W] == CMD_CLR_TX)
        act = '{kind: ACT_CLRTX, chan: 1'(c)};
      if (dataRead[c]) act = '{kind: ACT_READ, chan: 1'(c)};
      if (chanReset[c]) act = '{kind: ACT_RESET, chan: 1'(c)};
    end
  end
endmodule

// File: rtl/sio_irq_flags.sv
module sio_irq_flags
  import sio_irq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       statusHi,
  input  logic [NUM_CHAN-1:0]        txIntEn,
  input  logic [NUM_CHAN*MODE_W-1:0] rxIntMode,
  input  logic [NUM_CHAN-1:0]        brkIntEn,
  input  logic [NUM_CHAN-1:0]        brkStatus,
  input  actStrobe_t                 act,
  output logic                       irq,
  output logic [BYTE_W-1:0]          pendStatus,
  output logic [BYTE_W-1:0]          intVector
);
  logic [NUM_CHAN-1:0] rxPend, rxSvc, txPend, txSvc;
  logic [NUM_CHAN-1:0] rxPendNxt, rxSvcNxt, txPendNxt, txSvcNxt;
  logic [BYTE_W-1:0] statusNxt, vectorNxt;
  logic [NUM_CHAN-1:0] chanIrq;
  logic postRx, postTx, ch;
  logic irqQ;

  always_comb begin
    rxPendNxt = rxPend;
    rxSvcNxt  = rxSvc;
    txPendNxt = txPend;
    txSvcNxt  = txSvc;
    statusNxt = pendStatus;
    vectorNxt = intVector;
    postRx = 1'b0;
    postTx = 1'b0;
    ch = act.chan;
    case (act.kind)
      ACT_RESET: begin
        rxPendNxt[ch] = 1'b0;
        rxSvcNxt[ch]  = 1'b0;
        txPendNxt[ch] = 1'b0;
        txSvcNxt[ch]  = 1'b0;
        statusNxt = statusNxt & ~(rxMask(ch) | txMask(ch));
      end
      ACT_READ: begin
        rxPendNxt[ch] = 1'b0;
        rxSvcNxt[ch]  = 1'b0;
        vectorNxt = idleVec(statusHi);
        statusNxt = statusNxt & ~rxMask(ch);
        postTx = txPend[ch];
      end
      ACT_CLRTX: begin
        txPendNxt[ch] = 1'b0;
        txSvcNxt[ch]  = 1'b0;
        vectorNxt = idleVec(statusHi);
        statusNxt = statusNxt & ~txMask(ch);
        postRx = rxPend[ch];
      end
      ACT_RSTSVC: begin
        if (rxSvc[ch]) begin
          rxSvcNxt[ch] = 1'b0;
          postTx = txPend[ch];
        end else begin
          txSvcNxt[ch] = 1'b0;
        end
      end
      ACT_RX: postRx = 1'b1;
      ACT_TX: postTx = 1'b1;
      default: ;
    endcase
    if (postRx) begin
      rxPendNxt[ch] = 1'b1;
      rxSvcNxt[ch]  = 1'b1;
      statusNxt = statusNxt | rxMask(ch);
      vectorNxt = rxVec(ch, statusHi);
    end
    if (postTx) begin
      txPendNxt[ch] = 1'b1;
      if (!rxSvcNxt[ch]) begin
        txSvcNxt[ch] = 1'b1;
        if (txIntEn[ch]) statusNxt = statusNxt | txMask(ch);
        vectorNxt = txVec(ch, statusHi);
      end
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chanIrq
    logic rxModeOn;
    assign rxModeOn = (rxIntMode[g*MODE_W +: MODE_W] == 2'b01) ||
                      (rxIntMode[g*MODE_W +: MODE_W] == 2'b10);
    assign chanIrq[g] = (txIntEn[g] & txPendNxt[g]) |
                        (rxModeOn & rxPendNxt[g]) |
                        (brkIntEn[g] & brkStatus[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPend <= '0;
      rxSvc  <= '0;
      txPend <= '0;
      txSvc  <= '0;
      pendStatus <= '0;
      intVector  <= '0;
      irqQ <= 1'b0;
    end else begin
      rxPend <= rxPendNxt;
      rxSvc  <= rxSvcNxt;
      txPend <= txPendNxt;
      txSvc  <= txSvcNxt;
      pendStatus <= statusNxt;
      intVector  <= vectorNxt;
      irqQ <= |chanIrq;
    end
  end

  assign irq = irqQ;
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        statusHi,
  input  logic [1:0]  txIntEn,
  input  logic [3:0]  rxIntMode,
  input  logic [1:0]  brkIntEn,
  input  logic [1:0]  brkStatus,
  input  logic [1:0]  rxEvent,
  input  logic [1:0]  txEvent,
  input  logic [1:0]  dataRead,
  input  logic [1:0]  cmdWrite,
  input  logic [5:0]  cmdCode,
  input  logic [1:0]  chanReset,
  output logic        irq,
  output logic [7:0]  pendStatus,
  output logic [7:0]  intVector
);
  actStrobe_t act;

  sio_irq_arbiter u_arb (
    .chanReset(chanReset), .dataRead(dataRead), .cmdWrite(cmdWrite),
    .cmdCode(cmdCode), .rxEvent(rxEvent), .txEvent(txEvent), .act(act)
  );

  sio_irq_flags u_flags (
    .clk(clk), .rstN(rstN), .statusHi(statusHi), .txIntEn(txIntEn),
    .rxIntMode(rxIntMode), .brkIntEn(brkIntEn), .brkStatus(brkStatus),
    .act(act), .irq(irq), .pendStatus(pendStatus), .intVector(intVector)
  );
endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk (
  input logic        clk,
  input logic        rstN,
  input logic        statusHi,
  input logic [1:0]  txIntEn,
  input logic [3:0]  rxIntMode,
  input logic [1:0]  brkIntEn,
  input logic [1:0]  brkStatus,
  input logic [1:0]  rxEvent,
  input logic [1:0]  txEvent,
  input logic [1:0]  dataRead,
  input logic [1:0]  cmdWrite,
  input logic [5:0]  cmdCode,
  input logic [1:0]  chanReset,
  input logic        irq,
  input logic [7:0]  pendStatus,
  input logic [7:0]  intVector
);
  // R9: reset of channel A clears its two status bits
  a_r9_reset_clears_a: assert property (@(posedge clk) disable iff (!rstN)
    chanReset[0] |=> pendStatus[5:4] == 2'b00);

  // R7: a data read on channel A drops its rx status bit
  a_r7_read_clears_rx: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead[0] && !chanReset[0]) |=> !pendStatus[5]);

  // R2: receive on A, with no higher-ranked action, loads the rx code
  a_r2_rx_vector_a: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvent[0] && !chanReset[0] && !dataRead[0] && !cmdWrite[0])
    |=> pendStatus[5] && intVector == ($past(statusHi) ? 8'h30 : 8'h0C));

  // R8: no enabled source means no request on the next edge
  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (txIntEn == 2'b00 && brkIntEn == 2'b00 &&
     (rxIntMode[1:0] == 2'b00 || rxIntMode[1:0] == 2'b11) &&
     (rxIntMode[3:2] == 2'b00 || rxIntMode[3:2] == 2'b11)) |=> !irq);

  // R6: the A rx status bit only rises from a receive or a tx-clear re-post
  a_r6_rx_bit_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendStatus[5]) |->
      $past(rxEvent[0] || (cmdWrite[0] && cmdCode[2:0] == 3'b101)));
endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (.*);

// File: tb/test_sio_irq_vector.sv
`timescale 1ns/1ps
module test_sio_irq_vector;
  logic clk = 1'b0;
  logic rstN, statusHi;
  logic [1:0] txIntEn, brkIntEn, brkStatus, rxEvent, txEvent, dataRead, cmdWrite, chanReset;
  logic [3:0] rxIntMode;
  logic [5:0] cmdCode;
  logic irq;
  logic [7:0] pendStatus, intVector;

  always #2.5 clk = ~clk;

  sio_irq_vector i_sio_irq_vector (.*);

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  bit mRxP[2], mRxS[2], mTxP[2], mTxS[2];
  int mStat = 0, mVec = 0;
  bit mIrq = 0;

  function automatic int rxCodeOf(int c, bit hi);
    int tbl[4] = '{8'h0C, 8'h04, 8'h30, 8'h20};
    return tbl[(hi ? 2 : 0) + c];
  endfunction
  function automatic int txCodeOf(int c, bit hi);
    if (c == 1) return 0;
    return hi ? 8'h10 : 8'h08;
  endfunction

  task automatic doRx(int c);
    mRxP[c] = 1; mRxS[c] = 1;
    mStat |= (c == 0) ? 8'h20 : 8'h04;
    mVec = rxCodeOf(c, statusHi);
  endtask
  task automatic doTx(int c);
    mTxP[c] = 1;
    if (!mRxS[c]) begin
      mTxS[c] = 1;
      if (txIntEn[c]) mStat |= (c == 0) ? 8'h10 : 8'h02;
      mVec = txCodeOf(c, statusHi);
    end
  endtask

  task automatic modelStep();
    int kind = 0, ch = 0;
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin mRxP[c] = 0; mRxS[c] = 0; mTxP[c] = 0; mTxS[c] = 0; end
      mStat = 0; mVec = 0; mIrq = 0;
      return;
    end
    // R10: pick the single winning action
    for (int c = 1; c >= 0; c--) begin
      int cc;
      cc = (c == 0) ? cmdCode[2:0] : cmdCode[5:3];
      if (chanReset[c]) begin kind = 1; ch = c; end
      else if (dataRead[c]) begin kind = 2; ch = c; end
      else if (cmdWrite[c] && cc == 5) begin kind = 3; ch = c; end
      else if (cmdWrite[c] && cc == 7) begin kind = 4; ch = c; end
      else if (rxEvent[c]) begin kind = 5; ch = c; end
      else if (txEvent[c]) begin kind = 6; ch = c; end
    end
    case (kind)
      1: begin
        mRxP[ch] = 0; mRxS[ch] = 0; mTxP[ch] = 0; mTxS[ch] = 0;
        mStat &= (ch == 0) ? 8'hCF : 8'hF9;
      end
      2: begin
        mRxP[ch] = 0; mRxS[ch] = 0;
        mVec = statusHi ? 8'h60 : 8'h06;
        mStat &= (ch == 0) ? 8'hDF : 8'hFB;
        if (mTxP[ch]) doTx(ch);
      end
      3: begin
        mTxP[ch] = 0; mTxS[ch] = 0;
        mVec = statusHi ? 8'h60 : 8'h06;
        mStat &= (ch == 0) ? 8'hEF : 8'hFD;
        if (mRxP[ch]) doRx(ch);
      end
      4: begin
        if (mRxS[ch]) begin
          mRxS[ch] = 0;
          if (mTxP[ch]) doTx(ch);
        end else mTxS[ch] = 0;
      end
      5: doRx(ch);
      6: doTx(ch);
      default: ;
    endcase
    mIrq = 0;
    for (int c = 0; c < 2; c++) begin
      int mode;
      mode = (c == 0) ? rxIntMode[1:0] : rxIntMode[3:2];
      if (txIntEn[c] && mTxP[c]) mIrq = 1;
      if ((mode == 1 || mode == 2) && mRxP[c]) mIrq = 1;
      if (brkIntEn[c] && brkStatus[c]) mIrq = 1;
    end
  endtask

  task automatic compare();
    checks++;
    if (irq !== mIrq || pendStatus !== 8'(mStat) || intVector !== 8'(mVec)) begin
      failures++;
      $display("FAIL %s: irq=%0b status=%02h vector=%02h expected irq=%0b status=%02h vector=%02h",
               curReq, irq, pendStatus, intVector, mIrq, 8'(mStat), 8'(mVec));
    end
  endtask

  task automatic clearEvents();
    rxEvent = 0; txEvent = 0; dataRead = 0; cmdWrite = 0; chanReset = 0; cmdCode = 0;
  endtask

  // one edge: model advances, outputs checked at the following falling edge
  task automatic cycle();
    modelStep();
    @(negedge clk);
    compare();
    clearEvents();
  endtask

  task automatic cmd(int c, int code);
    cmdWrite[c] = 1;
    if (c == 0) cmdCode[2:0] = 3'(code); else cmdCode[5:3] = 3'(code);
    cycle();
  endtask

  initial begin
    rstN = 0; statusHi = 0; txIntEn = 2'b11; rxIntMode = 4'b1001;
    brkIntEn = 0; brkStatus = 0;
    clearEvents();
    @(negedge clk);
    curReq = "R1"; cycle(); cycle();
    rstN = 1;
    cycle();
    // R2: receive on A, low form
    curReq = "R2"; rxEvent[0] = 1; cycle();
    // R4: transmit while rx in service
    curReq = "R4"; txEvent[0] = 1; cycle();
    // R5: reset in-service re-posts tx
    curReq = "R5"; cmd(0, 7);
    // R7: data read clears rx, tx still shown
    curReq = "R7"; dataRead[0] = 1; cycle();
    // R6: clear tx, nothing left
    curReq = "R6"; cmd(0, 5);
    // R5: reset in-service with no rx in service clears tx service
    curReq = "R5"; txEvent[0] = 1; cycle(); cmd(0, 7); cmd(0, 5);
    // R2, R3, R6 on channel B with high form
    statusHi = 1;
    curReq = "R2"; rxEvent[1] = 1; cycle();
    curReq = "R3"; txEvent[1] = 1; cycle();
    curReq = "R6"; cmd(1, 5);
    curReq = "R7"; dataRead[1] = 1; cycle();
    curReq = "R3"; txEvent[1] = 1; cycle();
    // R3: tx on A with its enable off: vector loads, no status bit
    txIntEn = 2'b10; txEvent[0] = 1; cycle();
    cmd(0, 5); cmd(1, 5);
    txIntEn = 2'b11;
    // R8: break request and rx mode gating
    curReq = "R8"; brkIntEn = 2'b10; brkStatus = 2'b10; cycle();
    brkStatus = 0; cycle();
    rxIntMode = 4'b1100; rxEvent[0] = 1; cycle();
    rxIntMode = 4'b1001; cycle();
    dataRead[0] = 1; cycle();
    // R10: simultaneous receives, A wins; unknown code ignored
    curReq = "R10"; rxEvent = 2'b11; cycle();
    rxEvent[1] = 1; txEvent[0] = 1; cycle();
    cmd(1, 2);
    dataRead = 2'b11; cycle();
    // R9: channel reset touches only its own channel
    curReq = "R9"; rxEvent[1] = 1; cycle(); txEvent[0] = 1; cycle();
    chanReset[1] = 1; cycle();
    chanReset[0] = 1; cycle();
    // random phase, several actions may collide
    curReq = "R10";
    for (int i = 0; i < 2000; i++) begin
      statusHi = 1'($urandom);
      txIntEn = 2'($urandom); rxIntMode = 4'($urandom);
      brkIntEn = 2'($urandom); brkStatus = 2'($urandom & $urandom);
      rxEvent = 2'($urandom & $urandom); txEvent = 2'($urandom & $urandom);
      dataRead = 2'($urandom & $urandom); chanReset = 2'($urandom & $urandom & $urandom);
      cmdWrite = 2'($urandom); cmdCode = 6'($urandom);
      cycle();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule